// File: doc/BRIEF.md
# Transmit FIFO Empty Interrupt Generator

This block decides when a UART transmitter with a small transmit FIFO reports its holding register as empty, and when it raises the matching interrupt request. The block watches the FIFO occupancy, the FIFO-mode and transmit-interrupt enable bits, writes to the holding register and reads of the interrupt identification register. From these it produces a registered empty status and a registered interrupt request. The request is presented at the holding-register-empty priority level, which carries identification code 2. Arbitration against other interrupt sources is left to the surrounding logic.

The empty report is not always immediate. Suppose the FIFO has never held two or more characters at once since the status was last set, and the FIFO-mode bit has not changed. In that case the report is held back for one character time, less the final stop bit. The character time is counted in 16x baud ticks. A stop-bit-phase strobe from the shifter ends the wait early. A new character that arrives during the wait cancels it. If the FIFO did reach two or more entries, the report comes at once. The first report after the FIFO-mode bit changes also comes at once. Outside FIFO mode the report is always immediate and the interrupt is never raised.

Top module: `txe_irq_gen`

## Requirements
- R1: After reset, `thre` is 1 and `irq` is 0.
- R2: On any clock edge where `tx_count` is nonzero, `thre` is 0 after that edge.
- R3: If `tx_count` was 2 or more at some edge since `thre` was last 1, `thre` becomes 1 on the first edge at which `tx_count` is 0.
- R4: Otherwise, with `fifo_en`=1 and no toggle pending, `thre` rises after L+2 edges of continuous emptiness when `baud_tick` is 1 every cycle. Here L = (`char_bits`-1)×16, and `char_bits` counts start, data, parity and stop bits.
- R5: While a delayed report is waiting, `stop_phase`=1 at an edge makes `thre` 1 after that edge.
- R6: A nonzero `tx_count` during the wait aborts it. The next empty period restarts the full delay.
- R7: After `fifo_en` changes value, the next rise of `thre` is immediate. Later single-character rises are delayed again.
- R8: With `fifo_en`=0, `thre` rises on the first empty edge and `irq` stays 0. No interrupt latched in that mode survives a return to FIFO mode.
- R9: With `fifo_en`=1 and `tx_ie`=1, `irq` becomes 1 one edge after `thre` rises.
- R10: A pulse on `iid_rd` or `thr_wr` clears `irq` at the next edge. A rise of `thre` at the same edge takes precedence.
- R11: A rise of `thre` while `tx_ie`=0 is remembered. `irq` becomes 1 one edge after `tx_ie` is set.
- R12: The delay counter advances only on edges where `baud_tick` is 1. With `baud_tick` held at 0 the report never arrives; after ticks resume, `thre` rises after L+1 ticking edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_en | input | 1 | FIFO mode enable |
| tx_ie | input | 1 | Transmit-empty interrupt enable |
| tx_count | input | CW (5) | Transmit FIFO occupancy |
| thr_wr | input | 1 | Holding register write strobe |
| iid_rd | input | 1 | Interrupt identification read strobe |
| baud_tick | input | 1 | 16x baud enable |
| char_bits | input | 4 | Total bits per character frame |
| stop_phase | input | 1 | Shifter is in its final stop bit |
| thre | output | 1 | Holding register empty status |
| irq | output | 1 | Interrupt request, code 2 level |

## Verification
The assertions assume that `tx_count` behaves like a real FIFO occupancy. It rises only when a write strobe accompanies it, and it never exceeds the depth. They also assume the strobes are single-cycle and synchronous. The stimulus respects these assumptions: it raises `tx_count` only in the cycle in which it pulses `thr_wr`, and it lowers it only one step at a time. It holds `char_bits` and `baud_tick` stable while a delay is in flight, except in the deliberate tick-gating sweep. Each frame length from 4 to 12 bits is swept through the delayed path with exact edge counts.

// File: rtl/txe_pkg.sv
package txe_pkg;
  localparam int TICKS_PER_BIT = 16;

  function automatic int frame_delay(input int bits, input int ovs);
    if (bits < 1) return 0;
    return (bits - 1) * ovs;
  endfunction
endpackage

// File: rtl/txe_history.sv
module txe_history #(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fifo_en,
  input  logic [CW-1:0] tx_count,
  input  logic          thre,
  output logic          multi,
  output logic          first
);
  logic fen_prev_q;
  logic thre_prev_q;
  logic thre_rise;

  assign thre_rise = thre & ~thre_prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      multi       <= 1'b0;
      first       <= 1'b0;
      fen_prev_q  <= fifo_en;
      thre_prev_q <= 1'b1;
    end else begin
      fen_prev_q  <= fifo_en;
      thre_prev_q <= thre;
      multi       <= (tx_count >= CW'(2)) | (multi & ~thre);
      first       <= (fifo_en != fen_prev_q) | (first & ~thre_rise);
    end
  end
endmodule

// File: rtl/txe_delay_timer.sv
module txe_delay_timer #(
  parameter int OVS = 16,
  parameter int BW  = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          cancel,
  input  logic          baud_tick,
  input  logic          stop_phase,
  input  logic [BW-1:0] char_bits,
  output logic          done
);
  import txe_pkg::*;
  localparam int MAXLOAD = ((1 << BW) - 1) * OVS;
  localparam int TW      = $clog2(MAXLOAD + 1);

  logic          armed_q;
  logic [TW-1:0] cnt_q;
  logic [TW-1:0] load;

  assign load = TW'(frame_delay(int'(char_bits), OVS));
  assign done = armed_q & ((cnt_q == '0) | stop_phase);

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else if (cancel) begin
      armed_q <= 1'b0;
    end else if (start && !armed_q) begin
      armed_q <= 1'b1;
      cnt_q   <= load;
    end else if (armed_q && baud_tick && cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/txe_irq_latch.sv
module txe_irq_latch (
  input  logic clk,
  input  logic rst,
  input  logic thre,
  input  logic fifo_en,
  input  logic tx_ie,
  input  logic clr,
  output logic irq
);
  logic thre_prev_q;
  logic pend_q;
  logic pend_n;

  always_comb begin
    if (thre && !thre_prev_q) pend_n = 1'b1;
    else if (clr)             pend_n = 1'b0;
    else                      pend_n = pend_q;
    pend_n = pend_n & fifo_en;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      thre_prev_q <= 1'b1;
      pend_q      <= 1'b0;
      irq         <= 1'b0;
    end else begin
      thre_prev_q <= thre;
      pend_q      <= pend_n;
      irq         <= pend_n & fifo_en & tx_ie;
    end
  end
endmodule

// File: rtl/txe_irq_gen.sv
module txe_irq_gen #(
  parameter int DEPTH = 16,
  parameter int OVS   = txe_pkg::TICKS_PER_BIT,
  parameter int BW    = 4,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fifo_en,
  input  logic          tx_ie,
  input  logic [CW-1:0] tx_count,
  input  logic          thr_wr,
  input  logic          iid_rd,
  input  logic          baud_tick,
  input  logic [BW-1:0] char_bits,
  input  logic          stop_phase,
  output logic          thre,
  output logic          irq
);
  logic empty;
  logic multi;
  logic first;
  logic fast;
  logic start;
  logic done;
  logic thre_d;

  assign empty = (tx_count == '0);
  assign fast  = multi | first | ~fifo_en;
  assign start = empty & ~thre & ~fast;

  txe_history #(.CW(CW)) u_hist (
    .clk(clk), .rst(rst), .fifo_en(fifo_en), .tx_count(tx_count),
    .thre(thre), .multi(multi), .first(first)
  );

  txe_delay_timer #(.OVS(OVS), .BW(BW)) u_timer (
    .clk(clk), .rst(rst), .start(start), .cancel(~empty | thre),
    .baud_tick(baud_tick), .stop_phase(stop_phase),
    .char_bits(char_bits), .done(done)
  );

  always_comb begin
    if (!empty)     thre_d = 1'b0;
    else if (thre)  thre_d = 1'b1;
    else if (fast)  thre_d = 1'b1;
    else            thre_d = done;
  end

  always_ff @(posedge clk) begin
    if (rst) thre <= 1'b1;
    else     thre <= thre_d;
  end

  txe_irq_latch u_irq (
    .clk(clk), .rst(rst), .thre(thre), .fifo_en(fifo_en), .tx_ie(tx_ie),
    .clr(thr_wr | iid_rd), .irq(irq)
  );
endmodule

// File: rtl/txe_irq_gen_chk.sv
module txe_irq_gen_chk #(
  parameter int CW = 5
) (
  input logic          clk,
  input logic          rst,
  input logic          fifo_en,
  input logic          tx_ie,
  input logic [CW-1:0] tx_count,
  input logic          thr_wr,
  input logic          iid_rd,
  input logic          thre,
  input logic          irq
);
  p_busy_clears_thre_r2: assert property (@(posedge clk) disable iff (rst)
    (tx_count != '0) |=> !thre);

  p_empty_holds_thre_r3: assert property (@(posedge clk) disable iff (rst)
    (thre && tx_count == '0) |=> thre);

  p_gate_r8: assert property (@(posedge clk) disable iff (rst)
    !(fifo_en && tx_ie) |=> !irq);

  p_irq_follows_rise_r9: assert property (@(posedge clk) disable iff (rst)
    ($rose(thre) && fifo_en && tx_ie) |=> irq);

  p_strobe_clears_r10: assert property (@(posedge clk) disable iff (rst)
    ((thr_wr || iid_rd) && !$rose(thre)) |=> !irq);

  p_rise_only_empty_r6: assert property (@(posedge clk) disable iff (rst)
    (!thre && tx_count != '0) |=> !$rose(thre));
endmodule

bind txe_irq_gen txe_irq_gen_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst(rst), .fifo_en(fifo_en), .tx_ie(tx_ie), .tx_count(tx_count),
  .thr_wr(thr_wr), .iid_rd(iid_rd), .thre(thre), .irq(irq)
);

// File: tb/test_txe_irq_gen.sv
module test_txe_irq_gen;
  localparam int CW = 5;

  logic clk = 1'b0;
  logic rst;
  logic fifo_en, tx_ie, thr_wr, iid_rd, baud_tick, stop_phase;
  logic [CW-1:0] tx_count;
  logic [3:0] char_bits;
  logic thre, irq;

  int errors = 0;
  int checks = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  txe_irq_gen i_txe_irq_gen (
    .clk(clk), .rst(rst), .fifo_en(fifo_en), .tx_ie(tx_ie), .tx_count(tx_count),
    .thr_wr(thr_wr), .iid_rd(iid_rd), .baud_tick(baud_tick), .char_bits(char_bits),
    .stop_phase(stop_phase), .thre(thre), .irq(irq)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 100000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
    end
  endtask

  task automatic chk(input string req, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", req, got, exp);
    end
  endtask

  // single character written then drained: thre was 1 before the call
  task automatic one_char();
    tx_count = 1; thr_wr = 1; step(); thr_wr = 0;
    chk("R2 write clears thre", thre, 1'b0);
    tx_count = 0;
  endtask

  initial begin
    rst = 1; fifo_en = 1; tx_ie = 1; thr_wr = 0; iid_rd = 0; baud_tick = 1;
    stop_phase = 0; tx_count = 0; char_bits = 4'd10;
    step(3); rst = 0; step();
    chk("R1 thre after reset", thre, 1'b1);
    chk("R1 irq after reset", irq, 1'b0);

    // R4 sweep of frame lengths through the delayed path
    for (int b = 4; b <= 12; b++) begin
      int L;
      L = (b - 1) * 16;
      char_bits = 4'(b);
      one_char();
      step(L + 1);
      chk("R4 still waiting", thre, 1'b0);
      step();
      chk("R4 delayed rise", thre, 1'b1);
      step();
      chk("R9 irq after rise", irq, 1'b1);
      iid_rd = 1; step(); iid_rd = 0;
      chk("R10 read clears irq", irq, 1'b0);
      step(2);
    end

    // R3 two characters at once gives an immediate report
    char_bits = 4'd10;
    tx_count = 1; thr_wr = 1; step();
    tx_count = 2; step(); thr_wr = 0;
    tx_count = 1; step();
    tx_count = 0; step();
    chk("R3 immediate after two", thre, 1'b1);
    step();
    chk("R9 irq after immediate", irq, 1'b1);
    tx_count = 1; thr_wr = 1; step(); thr_wr = 0;
    chk("R10 write clears irq", irq, 1'b0);

    // R6 abort and restart
    tx_count = 0; step(5);
    chk("R6 waiting before abort", thre, 1'b0);
    tx_count = 1; thr_wr = 1; step(); thr_wr = 0;
    tx_count = 0;
    step(145);
    chk("R6 full delay restarted", thre, 1'b0);
    step();
    chk("R6 rise after restart", thre, 1'b1);
    step(3);

    // R5 stop phase ends the wait
    one_char();
    step(2);
    stop_phase = 1; step(); stop_phase = 0;
    chk("R5 stop phase ends wait", thre, 1'b1);
    step(3);

    // R7 toggle of fifo_en
    fifo_en = 0; step(); fifo_en = 1; step(2);
    one_char();
    step();
    chk("R7 first after toggle immediate", thre, 1'b1);
    step(3);
    one_char();
    step(2);
    chk("R7 next one delayed", thre, 1'b0);
    step(200);
    chk("R7 delayed one completes", thre, 1'b1);
    step(3);

    // R12 tick gating
    char_bits = 4'd7;
    baud_tick = 0;
    one_char();
    step(200);
    chk("R12 no ticks no report", thre, 1'b0);
    baud_tick = 1;
    step(96);
    chk("R12 waiting after L ticks", thre, 1'b0);
    step();
    chk("R12 rise after L+1 ticks", thre, 1'b1);
    step(3);

    // R8 non-FIFO mode
    fifo_en = 0;
    step();
    one_char();
    step();
    chk("R8 immediate in non-FIFO mode", thre, 1'b1);
    step(2);
    chk("R8 no irq in non-FIFO mode", irq, 1'b0);
    fifo_en = 1; step(3);
    chk("R8 nothing latched survives", irq, 1'b0);

    // R11 masked rise remembered
    tx_ie = 0;
    tx_count = 1; thr_wr = 1; step();
    tx_count = 2; step(); thr_wr = 0;
    tx_count = 0; step();
    chk("R11 rise while masked", thre, 1'b1);
    step(2);
    chk("R11 irq masked", irq, 1'b0);
    tx_ie = 1; step();
    chk("R11 irq once enabled", irq, 1'b1);

    // R10 coincident read and rise: rise wins
    iid_rd = 1; step(); iid_rd = 0;
    tx_count = 2; thr_wr = 1; step(); thr_wr = 0;
    tx_count = 0; step();
    iid_rd = 1; step(); iid_rd = 0;
    chk("R10 rise wins over read", irq, 1'b1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule